// File: doc/BRIEF.md
# ADC Frame Sequencer

This block is the digital timing core for a self-calibrating successive-approximation converter. It runs from a single master clock. After a synchronous reset it holds the standby flag low through a long calibration interval. It then repeats a fixed sample frame of three parts: a coarse-charge period, a fine-charge (tracking) period and a conversion period. During conversion a behavioural comparator model resolves one result bit every few clocks against the captured input value.

Each finished result is sent on a serial link during the following frame. The link has an internally generated serial clock at one quarter of the master clock, one data line and an active-low framing strobe. The strobe opens a guard interval of two clocks before the first rising serial-clock edge and closes one two clocks after the last. An optional channel-select output alternates between two inputs on every frame. A variant chosen by parameter waits after fine charge for an external hold request before it converts.

Top module: `adc_frame_sequencer`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the outputs after that edge are: `standby_o`=0, `strobe_n_o`=1, `sclk_o`=0, `track_o`=0, `coarse_o`=0 and `chan_sel_o`=0. This holds whatever the block was doing before.
- R2: After reset is released, `standby_o` stays low for exactly CAL_CYC rising edges, goes high on edge CAL_CYC and then stays high. `track_o` is low for as long as `standby_o` is low.
- R3: Each frame starts with `track_o` high for COARSE_CYC+FINE_CYC clocks (6+9=15). `coarse_o` is high for the first COARSE_CYC (6) of these clocks.
- R4: With FREE_RUN=1, frames repeat every COARSE_CYC+FINE_CYC+CONV_CYC clocks (80), and `hold_req_i` has no effect.
- R5: The value on `sample_i` at the last acquisition clock is converted to straight binary. Any value from 0 to 2^DATA_W-1 is reproduced exactly as the code sent in the next serial burst.
- R6: A `sample_i` value (signed) above 2^DATA_W-1 gives the all-ones code. A value below 0 gives the all-zeros code.
- R7: The serial word is DATA_W bits long and sent MSB first. `sclk_o` is high for SCK_HALF (2) clocks and low for SCK_HALF clocks. While the strobe is low, `sdata_o` changes only together with a falling `sclk_o`.
- R8: `strobe_n_o` falls at the clock edge that starts a frame, SCK_HALF clocks before the first rising `sclk_o`. It rises SCK_HALF clocks after the last rising `sclk_o`, on the same edge at which `sclk_o` falls. `sclk_o` is low whenever the strobe is high.
- R9: With `alt_en_i`=1, `chan_sel_o` inverts once per frame, on the frame-start edge. With `alt_en_i`=0 it holds its value.
- R10: With FREE_RUN=0, `track_o` stays high after fine charge until `hold_req_i` is sampled high on a falling clock edge. Conversion (`track_o` low) then begins at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| alt_en_i | input | 1 | Enables two-channel alternation |
| hold_req_i | input | 1 | Conversion start request (FREE_RUN=0 only) |
| sample_i | input | DATA_W+2 | Signed behavioural input value for the comparator model |
| standby_o | output | 1 | High once calibration has finished |
| track_o | output | 1 | High during acquisition |
| coarse_o | output | 1 | High during coarse charge |
| chan_sel_o | output | 1 | Selected input channel |
| sclk_o | output | 1 | Serial clock out |
| sdata_o | output | 1 | Serial data out, MSB first |
| strobe_n_o | output | 1 | Active-low serial framing strobe |

## Verification
On every cycle the assertions check these rules: the serial clock is idle while the strobe is high, data moves only on falling serial-clock edges, each serial-clock high phase has the right width, the strobe opens and closes in line with the serial clock, the standby flag is never lost, tracking stays off during calibration, and the channel select only changes when alternation is enabled. A counter in the checker also measures the free-running frame length. Only the bench scenarios show the converted values, the all-ones and all-zeros limits, the exact calibration length, the guard timing measured in clocks, and the hold-triggered start of conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   // Phases of the sample sequencer
   typedef enum logic [2:0] {
      PH_CAL    = 3'd0,
      PH_COARSE = 3'd1,
      PH_FINE   = 3'd2,
      PH_WAIT   = 3'd3,
      PH_CONV   = 3'd4
   } phase_e;

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
   import adc_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int COARSE_CYC = 6,
   parameter int FINE_CYC   = 9,
   parameter int CONV_CYC   = 65,
   parameter int CAL_CYC    = 2882040,
   parameter int FREE_RUN   = 1
) (
   input  logic   clk_i,
   input  logic   rst_i,
   input  logic   hold_q_i,
   output phase_e phase_o,
   output logic   go_conv_o,
   output logic   sar_step_o,
   output logic   frame_end_o
);

   localparam int MAX_A    = (COARSE_CYC > FINE_CYC) ? COARSE_CYC : FINE_CYC;
   localparam int MAX_PH   = (MAX_A > CONV_CYC) ? MAX_A : CONV_CYC;
   localparam int PH_W     = $clog2(MAX_PH + 1);
   localparam int CAL_W    = $clog2(CAL_CYC + 1);
   localparam int BIT_CYC  = (CONV_CYC - 1) / DATA_W;
   localparam int STEP_END = DATA_W * BIT_CYC;

   phase_e            phase_q, phase_d;
   logic [CAL_W-1:0]  cal_q;
   logic [PH_W-1:0]   cnt_q;
   logic              go_conv, frame_end;

   always_comb begin
      phase_d   = phase_q;
      go_conv   = 1'b0;
      frame_end = 1'b0;
      case (phase_q)
         PH_CAL: begin
            if (cal_q == CAL_W'(CAL_CYC - 1)) phase_d = PH_COARSE;
         end
         PH_COARSE: begin
            if (cnt_q == PH_W'(COARSE_CYC - 1)) phase_d = PH_FINE;
         end
         PH_FINE: begin
            if (cnt_q == PH_W'(FINE_CYC - 1)) begin
               if (FREE_RUN != 0) begin
                  phase_d = PH_CONV;
                  go_conv = 1'b1;
               end else begin
                  phase_d = PH_WAIT;
               end
            end
         end
         PH_WAIT: begin
            if (hold_q_i) begin
               phase_d = PH_CONV;
               go_conv = 1'b1;
            end
         end
         PH_CONV: begin
            if (cnt_q == PH_W'(CONV_CYC - 1)) begin
               phase_d   = PH_COARSE;
               frame_end = 1'b1;
            end
         end
         default: phase_d = PH_CAL;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         phase_q <= PH_CAL;
         cal_q   <= '0;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_CAL) cal_q <= cal_q + 1'b1;
         if (phase_d != phase_q)
            cnt_q <= '0;
         else if (phase_q != PH_WAIT && phase_q != PH_CAL)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign phase_o     = phase_q;
   assign go_conv_o   = go_conv;
   assign frame_end_o = frame_end;
   assign sar_step_o  = (phase_q == PH_CONV) && (cnt_q < PH_W'(STEP_END)) &&
                        ((cnt_q % PH_W'(BIT_CYC)) == PH_W'(BIT_CYC - 1));

endmodule

// File: rtl/adc_sar_model.sv
module adc_sar_model #(
   parameter int DATA_W = 16
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     load_i,
   input  logic                     step_i,
   input  logic signed [DATA_W+1:0] sample_i,
   output logic        [DATA_W-1:0] result_o
);

   localparam logic signed [DATA_W+1:0] TOP_V = {2'b00, {DATA_W{1'b1}}};

   logic [DATA_W-1:0] held_q, acc_q, trial_q, clamped;

   // Out-of-range inputs saturate to the code limits
   always_comb begin
      if (sample_i < 0)
         clamped = '0;
      else if (sample_i > TOP_V)
         clamped = '1;
      else
         clamped = sample_i[DATA_W-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         held_q  <= '0;
         acc_q   <= '0;
         trial_q <= '0;
      end else if (load_i) begin
         held_q  <= clamped;
         acc_q   <= '0;
         trial_q <= {1'b1, {(DATA_W-1){1'b0}}};
      end else if (step_i) begin
         if ((acc_q | trial_q) <= held_q) acc_q <= acc_q | trial_q;
         trial_q <= trial_q >> 1;
      end
   end

   assign result_o = acc_q;

endmodule

// File: rtl/adc_ser_tx.sv
module adc_ser_tx #(
   parameter int DATA_W   = 16,
   parameter int SCK_HALF = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] word_i,
   output logic              sclk_o,
   output logic              sdata_o,
   output logic              strobe_n_o
);

   localparam int PER   = 2 * SCK_HALF;
   localparam int TOTAL = DATA_W * PER;
   localparam int CW    = $clog2(TOTAL + 1);

   logic              busy_q, sclk_q, sdata_q, strobe_n_q;
   logic [CW-1:0]     cnt_q, cnt_nx;
   logic [DATA_W-1:0] shreg_q;

   assign cnt_nx = cnt_q + 1'b1;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         busy_q     <= 1'b0;
         cnt_q      <= '0;
         shreg_q    <= '0;
         sclk_q     <= 1'b0;
         sdata_q    <= 1'b0;
         strobe_n_q <= 1'b1;
      end else if (load_i) begin
         busy_q     <= 1'b1;
         cnt_q      <= '0;
         shreg_q    <= word_i;
         sdata_q    <= word_i[DATA_W-1];
         sclk_q     <= 1'b0;
         strobe_n_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == CW'(TOTAL)) begin
            busy_q     <= 1'b0;
            sclk_q     <= 1'b0;
            strobe_n_q <= 1'b1;
         end else begin
            sclk_q <= ((cnt_nx % CW'(PER)) >= CW'(SCK_HALF));
            if ((cnt_nx % CW'(PER)) == '0) begin
               sdata_q <= shreg_q[DATA_W-2];
               shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sclk_o     = sclk_q;
   assign sdata_o    = sdata_q;
   assign strobe_n_o = strobe_n_q;

endmodule

// File: rtl/adc_frame_sequencer.sv
module adc_frame_sequencer
   import adc_seq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int COARSE_CYC = 6,
   parameter int FINE_CYC   = 9,
   parameter int CONV_CYC   = 65,
   parameter int CAL_CYC    = 2882040,
   parameter int SCK_HALF   = 2,
   parameter int FREE_RUN   = 1
) (
   input  logic                     clk_i,
   input  logic                     rst_i,
   input  logic                     alt_en_i,
   input  logic                     hold_req_i,
   input  logic signed [DATA_W+1:0] sample_i,
   output logic                     standby_o,
   output logic                     track_o,
   output logic                     coarse_o,
   output logic                     chan_sel_o,
   output logic                     sclk_o,
   output logic                     sdata_o,
   output logic                     strobe_n_o
);

   localparam int FRAME_CYC = COARSE_CYC + FINE_CYC + CONV_CYC;
   localparam int SER_CYC   = DATA_W * 2 * SCK_HALF;

   // Elaboration-time parameter checks
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (COARSE_CYC < 1 || FINE_CYC < 1 || CAL_CYC < 1) begin : g_bad_phase
      $error("phase lengths must be at least one clock");
   end
   if ((CONV_CYC - 1) / DATA_W < 1) begin : g_bad_conv
      $error("CONV_CYC too short for one clock per bit");
   end
   if (SCK_HALF < 1 || SER_CYC >= FRAME_CYC) begin : g_bad_ser
      $error("serial burst must fit inside one frame");
   end

   phase_e            phase;
   logic              go_conv, sar_step, frame_end, hold_q, chan_q;
   logic [DATA_W-1:0] result;

   // Variant: hold request sampled on the falling clock edge
   if (FREE_RUN != 0) begin : g_free
      logic unused_hold;
      assign unused_hold = hold_req_i;
      assign hold_q      = 1'b0;
   end else begin : g_hold
      always_ff @(negedge clk_i) begin
         if (rst_i) hold_q <= 1'b0;
         else       hold_q <= hold_req_i;
      end
   end

   adc_seq_timer #(
      .DATA_W    (DATA_W),
      .COARSE_CYC(COARSE_CYC),
      .FINE_CYC  (FINE_CYC),
      .CONV_CYC  (CONV_CYC),
      .CAL_CYC   (CAL_CYC),
      .FREE_RUN  (FREE_RUN)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .hold_q_i   (hold_q),
      .phase_o    (phase),
      .go_conv_o  (go_conv),
      .sar_step_o (sar_step),
      .frame_end_o(frame_end)
   );

   adc_sar_model #(.DATA_W(DATA_W)) u_sar (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .load_i  (go_conv),
      .step_i  (sar_step),
      .sample_i(sample_i),
      .result_o(result)
   );

   adc_ser_tx #(.DATA_W(DATA_W), .SCK_HALF(SCK_HALF)) u_tx (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .load_i    (frame_end),
      .word_i    (result),
      .sclk_o    (sclk_o),
      .sdata_o   (sdata_o),
      .strobe_n_o(strobe_n_o)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)                      chan_q <= 1'b0;
      else if (frame_end && alt_en_i) chan_q <= ~chan_q;
   end

   assign chan_sel_o = chan_q;
   assign standby_o  = (phase != PH_CAL);
   assign coarse_o   = (phase == PH_COARSE);
   assign track_o    = (phase == PH_COARSE) || (phase == PH_FINE) || (phase == PH_WAIT);

endmodule

// File: rtl/adc_seq_checks.sv
module adc_seq_checks #(
   parameter int FRAME_CYC = 80,
   parameter int FREE_RUN  = 1
) (
   input logic clk_i,
   input logic rst_i,
   input logic alt_en_i,
   input logic standby_o,
   input logic track_o,
   input logic chan_sel_o,
   input logic sclk_o,
   input logic sdata_o,
   input logic strobe_n_o
);

   localparam int FW = $clog2(FRAME_CYC + 2);

   logic          track_d, seen_q;
   logic [FW-1:0] frm_q;

   // Frame-length window measured by a counter
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         track_d <= 1'b0;
         seen_q  <= 1'b0;
         frm_q   <= '0;
      end else begin
         track_d <= track_o;
         if (track_o && !track_d) begin
            seen_q <= 1'b1;
            frm_q  <= '0;
         end else if (frm_q != '1) begin
            frm_q <= frm_q + 1'b1;
         end
      end
   end

   // R8: serial clock idle while strobe inactive
   a_r8_sclk_idle: assert property (@(posedge clk_i) disable iff (rst_i)
      strobe_n_o |-> !sclk_o);

   // R8: strobe closes together with the last falling serial clock
   a_r8_strobe_close: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(strobe_n_o) |-> $fell(sclk_o));

   // R7: data moves only on falling serial clock inside a burst
   a_r7_data_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
      (!strobe_n_o && $past(!strobe_n_o) && !$stable(sdata_o)) |-> $fell(sclk_o));

   // R7: serial clock high phase lasts two clocks
   a_r7_sclk_high: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(sclk_o) |=> sclk_o ##1 !sclk_o);

   // R2: standby never drops outside reset
   a_r2_standby_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      !$fell(standby_o));

   // R2: no tracking during calibration
   a_r2_no_track_in_cal: assert property (@(posedge clk_i) disable iff (rst_i)
      !standby_o |-> !track_o);

   // R9: channel select static when alternation is off
   a_r9_chan_static: assert property (@(posedge clk_i) disable iff (rst_i)
      !alt_en_i |=> $stable(chan_sel_o));

   // R4: free-running frame period
   a_r4_frame_len: assert property (@(posedge clk_i) disable iff (rst_i)
      (FREE_RUN != 0 && track_o && !track_d && seen_q) |-> (frm_q == FW'(FRAME_CYC - 1)));

endmodule

bind adc_frame_sequencer adc_seq_checks #(
   .FRAME_CYC(FRAME_CYC),
   .FREE_RUN (FREE_RUN)
) u_seq_checks (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .alt_en_i  (alt_en_i),
   .standby_o (standby_o),
   .track_o   (track_o),
   .chan_sel_o(chan_sel_o),
   .sclk_o    (sclk_o),
   .sdata_o   (sdata_o),
   .strobe_n_o(strobe_n_o)
);

// File: tb/test_adc_frame_sequencer.sv
module test_adc_frame_sequencer;

   localparam int DW  = 16;
   localparam int CAL = 200;
   localparam int TCK = 8;
   localparam int NV  = 8;

   localparam logic signed [DW+1:0] VIN [NV] = '{
      18'sd0, 18'sd1234, 18'sd65535, 18'sd70000,
      -18'sd5, 18'sd32768, 18'sd21845, 18'sd43690 };
   localparam logic [DW-1:0] VEXP [NV] = '{
      16'd0, 16'd1234, 16'd65535, 16'd65535,
      16'd0, 16'd32768, 16'd21845, 16'd43690 };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst = 1'b1, alt_en = 1'b1, hold = 1'b0;
   logic signed [DW+1:0] sample = '0;
   logic standby, track, coarse, chan, sclk, sdata, strobe_n;
   logic h_standby, h_track, h_coarse, h_chan, h_sclk, h_sdata, h_strobe_n;

   int checks = 0;
   int errors = 0;

   adc_frame_sequencer #(.DATA_W(DW), .CAL_CYC(CAL), .FREE_RUN(1)) i_adc_frame_sequencer (
      .clk_i(clk), .rst_i(rst), .alt_en_i(alt_en), .hold_req_i(hold), .sample_i(sample),
      .standby_o(standby), .track_o(track), .coarse_o(coarse), .chan_sel_o(chan),
      .sclk_o(sclk), .sdata_o(sdata), .strobe_n_o(strobe_n));

   adc_frame_sequencer #(.DATA_W(DW), .CAL_CYC(CAL), .FREE_RUN(0)) i_adc_frame_sequencer_hold (
      .clk_i(clk), .rst_i(rst), .alt_en_i(alt_en), .hold_req_i(hold), .sample_i(sample),
      .standby_o(h_standby), .track_o(h_track), .coarse_o(h_coarse), .chan_sel_o(h_chan),
      .sclk_o(h_sclk), .sdata_o(h_sdata), .strobe_n_o(h_strobe_n));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(TCK * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      time ta, tb, tc, td, t0, t1, t2, tl, te;
      logic c1, c2;
      logic [DW-1:0] word;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(standby == 0, "R1 standby", standby, 0);
      chk(strobe_n == 1, "R1 strobe", strobe_n, 1);
      chk(sclk == 0, "R1 sclk", sclk, 0);
      chk(track == 0 && coarse == 0, "R1 track", track, 0);
      chk(chan == 0, "R1 chan", chan, 0);
      rst = 1'b0;

      // R2: calibration length
      repeat (CAL - 1) @(posedge clk);
      #1;
      chk(standby == 0, "R2 standby before end", standby, 0);
      @(posedge clk);
      #1;
      chk(standby == 1, "R2 standby at end", standby, 1);
      chk(track == 1 && coarse == 1, "R2 frame starts", track, 1);

      // R10: hold variant waits, then converts after falling-edge sample
      repeat (40) @(posedge clk);
      #1;
      chk(h_track == 1, "R10 waiting in track", h_track, 1);
      hold = 1'b1;
      @(negedge clk);
      #1;
      chk(h_track == 1, "R10 no start before rising edge", h_track, 1);
      @(posedge clk);
      #1;
      chk(h_track == 0, "R10 conversion started", h_track, 0);

      // R3/R4/R9: phase widths, frame period with hold high, channel toggle
      @(posedge track);
      ta = $time;
      #1 c1 = chan;
      @(negedge coarse);
      tb = $time;
      @(negedge track);
      tc = $time;
      @(posedge track);
      td = $time;
      #1 c2 = chan;
      chk(tb - ta == 6 * TCK, "R3 coarse width", tb - ta, 6 * TCK);
      chk(tc - ta == 15 * TCK, "R3 track width", tc - ta, 15 * TCK);
      chk(td - ta == 80 * TCK, "R4 frame period", td - ta, 80 * TCK);
      chk(c1 != c2, "R9 chan toggles", c2, !c1);
      hold = 1'b0;

      // R5/R6/R7/R8: table of inputs and expected codes
      for (int i = 0; i < NV; i++) begin
         @(posedge track);
         #1 sample = VIN[i];
         @(negedge strobe_n);
         t0 = $time;
         word = '0;
         for (int b = 0; b < DW; b++) begin
            @(posedge sclk);
            if (b == 0) t1 = $time;
            if (b == 1) t2 = $time;
            tl = $time;
            #1 word = {word[DW-2:0], sdata};
         end
         @(posedge strobe_n);
         te = $time;
         chk(word == VEXP[i], (VIN[i] < 0 || VIN[i] > 65535) ? "R6 clamp code" : "R5 code",
             word, VEXP[i]);
         chk(t1 - t0 == 2 * TCK, "R8 lead guard", t1 - t0, 2 * TCK);
         chk(te - tl == 2 * TCK, "R8 trail guard", te - tl, 2 * TCK);
         chk(t2 - t1 == 4 * TCK, "R7 sclk period", t2 - t1, 4 * TCK);
      end

      // R9: alternation disabled holds the channel
      @(posedge track);
      #1 alt_en = 1'b0;
      c1 = chan;
      @(posedge track);
      @(posedge track);
      #1 c2 = chan;
      chk(c1 == c2, "R9 chan held", c2, c1);

      // R1: reset in the middle of a serial burst
      @(posedge sclk);
      #1 rst = 1'b1;
      @(posedge clk);
      #1;
      chk(strobe_n == 1, "R1 mid strobe", strobe_n, 1);
      chk(sclk == 0, "R1 mid sclk", sclk, 0);
      chk(standby == 0 && track == 0, "R1 mid standby", standby, 0);
      rst = 1'b0;

      finish_run();
   end

endmodule